// File: doc/BRIEF.md
# Branch History Ring

This block keeps a short history of the most recent control-flow transfers seen by a processor core. Every taken branch, interrupt or exception is reported on one event strobe together with its source and destination addresses. When recording is enabled, the block advances a newest-entry pointer around a ring of eight slots. It then stores the address pair as one 64-bit word in the slot the pointer now names. When the ring is full, the oldest slot is overwritten without any notice.

Debug or profiling logic reads the history through an indexed read port that returns any slot one cycle after the index is presented. It also reads the pointer, which is a wide register whose unused upper bits are zero. Together these let a reader rebuild the history from newest to oldest. The block does not detect events, and it does not filter by the kind of transfer.

Top module: `bhr_top`

## Requirements
- R1: The ring holds exactly 8 slots, indexed 0 to 7, and every slot can be read through the read port.
- R2: A stored slot word carries the source address in bits 31:0 and the destination address in bits 63:32.
- R3: On a recorded event, the pointer first advances by one, with 7 followed by 0. The new word is then written into the slot at the advanced pointer value.
- R4: An event strobe is ignored while the recording enable is low, and no event is recorded while the strobe is low. In both cases the pointer and all slot contents stay unchanged.
- R5: Reading through the read port changes neither the pointer nor any slot.
- R6: The read data is registered. After a clock edge, rd_data_o holds the slot named by rd_idx_i at that edge. If the same slot is written at that edge, rd_data_o shows its previous contents.
- R7: While reset is asserted, and after it is released, the pointer is 0, every slot reads as zero and rd_data_o is zero.
- R8: Bits of tos_o above bit 2 always read as zero, and bits 2:0 carry the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rec_en_i | input | 1 | Recording enable |
| evt_vld_i | input | 1 | Control-flow transfer strobe, one event per cycle |
| evt_from_i | input | 32 | Source address of the transfer |
| evt_to_i | input | 32 | Destination address of the transfer |
| rd_idx_i | input | 3 | Slot index for the read port |
| rd_data_o | output | 64 | Registered slot word |
| tos_o | output | 64 | Newest-entry pointer, zero-extended |

## Verification
The bench builds the block with its default parameters: 8 slots, 32-bit addresses and a 64-bit pointer readout. With only eight slots, a wrap happens after every eighth recorded event. Random traffic therefore crosses the 7-to-0 boundary many times and often overwrites slots that still hold older data. The narrow index also makes a read and a write to the same slot in the same cycle frequent under random stimulus, and directed cases force that collision as well.

// File: rtl/bhr_pkg.sv
package bhr_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 2 * ADDR_W;

  // Destination occupies the upper half, source the lower half.
  typedef struct packed {
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
  } slot_t;
endpackage

// File: rtl/bhr_ptr.sv
module bhr_ptr #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rec_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] wr_idx_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (rec_i) begin
      if (ptr_q == LAST) ptr_d = '0;
      else               ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ptr_q <= '0;
    else if (rec_i) ptr_q <= ptr_d;
  end

  assign ptr_o    = ptr_q;
  assign wr_idx_o = ptr_d;

  // R4: without a recorded event the pointer holds
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_i |=> $stable(ptr_q));
  // R3: the last slot is followed by slot 0
  a_r3_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_i && ptr_q == LAST) |=> (ptr_q == '0));
  // R3: otherwise the pointer steps by one
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_i && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/bhr_store.sv
module bhr_store
  import bhr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [PTR_W-1:0] wr_idx_i,
  input  slot_t            wr_data_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output slot_t            rd_data_o
);
  slot_t entry_q [DEPTH];
  slot_t rd_q;
  slot_t rd_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic  we;
    slot_t entry_d;

    always_comb begin
      we      = wr_en_i && (wr_idx_i == PTR_W'(g));
      entry_d = we ? wr_data_i : entry_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  entry_q[g] <= '0;
      else if (we) entry_q[g] <= entry_d;
    end

    // R4 / R5: a slot changes only when it is the write target
    a_r4_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && wr_idx_i == PTR_W'(g)) |=> $stable(entry_q[g]));
  end

  always_comb rd_d = entry_q[rd_idx_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;

  // R3: the written slot holds the new word after the edge
  a_r3_slot_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (entry_q[$past(wr_idx_i)] == $past(wr_data_i)));
  // R6: a colliding read returns the word that was replaced
  a_r6_read_old: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i == rd_idx_i) |=> (rd_q == $past(entry_q[rd_idx_i])));
endmodule

// File: rtl/bhr_top.sv
module bhr_top
  import bhr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TOS_W = 64,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rec_en_i,
  input  logic              evt_vld_i,
  input  logic [ADDR_W-1:0] evt_from_i,
  input  logic [ADDR_W-1:0] evt_to_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [TOS_W-1:0]  tos_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             rec;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] wr_idx;
  slot_t            wr_word;
  slot_t            rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    rec         = evt_vld_i && rec_en_i;
    wr_word.src = evt_from_i;
    wr_word.dst = evt_to_i;
  end

  bhr_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rec_i    (rec),
    .ptr_o    (ptr),
    .wr_idx_o (wr_idx)
  );

  bhr_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_en_i   (rec),
    .wr_idx_i  (wr_idx),
    .wr_data_i (wr_word),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_word)
  );

  assign rd_data_o = rd_word;
  assign tos_o     = TOS_W'(ptr);

  // R8: the pointer readout never carries upper bits, checked on the port
  a_r8_tos_upper: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tos_o >> PTR_W) == '0);
endmodule

// File: tb/bhr_top_tb_top.sv
module bhr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rec_en_i;
  logic        evt_vld_i;
  logic [31:0] evt_from_i;
  logic [31:0] evt_to_i;
  logic [2:0]  rd_idx_i;
  logic [63:0] rd_data_o;
  logic [63:0] tos_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] m_mem [8];
  logic [2:0]  m_ptr;

  always #5 clk = ~clk;

  bhr_top dut_i (
    .clk(clk), .rst_n(rst_n), .rec_en_i(rec_en_i), .evt_vld_i(evt_vld_i),
    .evt_from_i(evt_from_i), .evt_to_i(evt_to_i), .rd_idx_i(rd_idx_i),
    .rd_data_o(rd_data_o), .tos_o(tos_o)
  );

  function automatic logic [63:0] pack_word(logic [31:0] f, logic [31:0] t);
    return {t, f};
  endfunction

  function automatic logic [2:0] ring_next(logic [2:0] p);
    return (p == 3'd7) ? 3'd0 : p + 3'd1;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one cycle at the falling edge and compares just after the rising edge.
  task automatic step(string req, logic ev, logic en, logic [31:0] f,
                      logic [31:0] t, logic [2:0] idx);
    logic [63:0] exp_rd;
    evt_vld_i = ev; rec_en_i = en; evt_from_i = f; evt_to_i = t; rd_idx_i = idx;
    exp_rd = m_mem[idx];
    if (ev && en) begin
      m_ptr = ring_next(m_ptr);
      m_mem[m_ptr] = pack_word(f, t);
    end
    @(posedge clk); #2;
    check(req, rd_data_o, exp_rd);
    check("R3 R8 pointer", tos_o, {61'd0, m_ptr});
    @(negedge clk);
  endtask

  task automatic read_all(string req);
    for (int k = 0; k < 8; k++) step(req, 1'b0, 1'b0, 32'h0, 32'h0, 3'(k));
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1badcafe));
    rst_n = 1'b0; rec_en_i = 1'b0; evt_vld_i = 1'b0;
    evt_from_i = '0; evt_to_i = '0; rd_idx_i = '0;
    m_ptr = '0;
    for (int k = 0; k < 8; k++) m_mem[k] = '0;
    #1;
    check("R7 reset pointer", tos_o, 64'd0);
    check("R7 reset read", rd_data_o, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    read_all("R7 R1 reset slots");

    // R2 packing: source low half, destination high half
    step("R2 R3 first write", 1'b1, 1'b1, 32'h1111_aaaa, 32'h2222_bbbb, 3'd0);
    step("R2 packing", 1'b0, 1'b0, 32'h0, 32'h0, 3'd1);
    check("R2 low half", rd_data_o[31:0], 64'h1111_aaaa);
    check("R2 high half", rd_data_o[63:32], 64'h2222_bbbb);

    // R3 wrap: fill all slots, pointer goes 7 -> 0
    for (int k = 0; k < 7; k++)
      step("R3 fill", 1'b1, 1'b1, 32'h100 + k, 32'h200 + k, 3'(k));
    check("R3 wrapped pointer", tos_o, 64'd0);
    read_all("R1 R3 ring contents");

    // R4: strobe with enable low and enable without strobe change nothing
    step("R4 disabled event", 1'b1, 1'b0, 32'hdead_0001, 32'hdead_0002, 3'd1);
    step("R4 idle enable", 1'b0, 1'b1, 32'hdead_0003, 32'hdead_0004, 3'd2);
    read_all("R4 R5 contents kept");

    // R6: read and write of the same slot in one cycle
    step("R6 collision", 1'b1, 1'b1, 32'hc0ff_ee01, 32'hc0ff_ee02, ring_next(m_ptr));
    step("R6 new value", 1'b0, 1'b0, 32'h0, 32'h0, m_ptr);

    // Random traffic
    for (int n = 0; n < 3000; n++)
      step("R3 R4 R6 random", 1'($urandom), ($urandom % 4) != 0,
           $urandom, $urandom, 3'($urandom));
    read_all("R5 final contents");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule